// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion and fault events from up to sixteen DMA channels and turns them into a single interrupt line and a small register file. Each channel sends three kinds of single-cycle pulse: terminal count, error class one and error class two. Each pulse sets a sticky bit in the raw latch word for its class. A per-class enable word selects which of those latched bits reach the masked views. Software reads the masked views to find the channels that need service. It acknowledges events by writing ones to the raw latch addresses. To retire a terminated channel, it writes that channel's bit to all three raw addresses.

The block also exposes the channels' busy levels as one status word and holds a channel priority word. The priority word is stored and read back; a value of zero means every channel has the same priority. The interrupt output is high whenever any enabled event is latched, one clock after the latch.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, all three raw latch words, all three enable words, the priority word and `irq` read as zero.
- R2: A pulse on bit i of `tc_evt`, `err1_evt` or `err2_evt` sets bit i of that class's raw word (terminal count at 0x600, error one at 0x610, error two at 0x618) on the next clock edge, and the bit stays set until software clears it.
- R3: A write to a raw latch address clears each bit where `wdata` holds a one and leaves the bits where `wdata` holds a zero unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The enable words for terminal count, error one and error two sit at 0x18, 0x20 and 0x24. They hold the low NCH bits of the last value written, and a bit of 1 enables that channel. Bits at and above NCH read as zero.
- R6: The masked words for terminal count at 0x04, error one at 0x0C and error two at 0x10 each read as that class's raw word ANDed with its enable word.
- R7: The word at 0x00 reads as the OR of the three masked words.
- R8: `irq` is high in the cycle after the word at 0x00 is nonzero, and low in the cycle after it is zero.
- R9: The word at 0x690 returns the `busy` inputs in the same cycle, bit i for channel i.
- R10: The priority word at 0x688 stores every bit written to it and reads it back.
- R11: Writes to 0x00, 0x04, 0x0C, 0x10 and 0x690 change no state, and reads of any address outside the map return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_evt | input | NCH | Terminal-count pulse per channel |
| err1_evt | input | NCH | Error class one pulse per channel |
| err2_evt | input | NCH | Error class two pulse per channel |
| busy | input | NCH | Running level per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte address, for both read and write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
Several checks run on every cycle. A pulse must leave its raw bit set on the next edge. No raw bit may rise without a pulse in the cycle before. A clearing write must drop every targeted bit that had no pulse in the same cycle. An enable word may change only on a write to its own address. The interrupt line must equal the previous cycle's OR of enabled latched events. The bench scenarios cover the remaining behaviour: the address map, the zero padding of the upper bits, the pass-through of the busy word, and the priority word read-back. They also cover the same-cycle race between a pulse and a clear, and confirm that writes to status addresses change no state.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] tc_evt,
  input  logic [NCH-1:0] err1_evt,
  input  logic [NCH-1:0] err2_evt,
  input  logic [NCH-1:0] busy,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_COMB   = AW'(12'h000);
  localparam logic [AW-1:0] A_M_TC   = AW'(12'h004);
  localparam logic [AW-1:0] A_M_E1   = AW'(12'h00C);
  localparam logic [AW-1:0] A_M_E2   = AW'(12'h010);
  localparam logic [AW-1:0] A_EN_TC  = AW'(12'h018);
  localparam logic [AW-1:0] A_EN_E1  = AW'(12'h020);
  localparam logic [AW-1:0] A_EN_E2  = AW'(12'h024);
  localparam logic [AW-1:0] A_RAW_TC = AW'(12'h600);
  localparam logic [AW-1:0] A_RAW_E1 = AW'(12'h610);
  localparam logic [AW-1:0] A_RAW_E2 = AW'(12'h618);
  localparam logic [AW-1:0] A_PRIO   = AW'(12'h688);
  localparam logic [AW-1:0] A_BUSY   = AW'(12'h690);

  logic [NCH-1:0] raw_tc, raw_e1, raw_e2;
  logic [NCH-1:0] en_tc, en_e1, en_e2;
  logic [DW-1:0]  prio;
  logic [NCH-1:0] m_tc, m_e1, m_e2, comb;
  logic [NCH-1:0] wlo;

  assign wlo  = wdata[NCH-1:0];
  assign m_tc = raw_tc & en_tc;
  assign m_e1 = raw_e1 & en_e1;
  assign m_e2 = raw_e2 & en_e2;
  assign comb = m_tc | m_e1 | m_e2;

  function automatic logic [NCH-1:0] clr(input logic hit, input logic [NCH-1:0] w);
    return hit ? w : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc <= '0;
      raw_e1 <= '0;
      raw_e2 <= '0;
      en_tc  <= '0;
      en_e1  <= '0;
      en_e2  <= '0;
      prio   <= '0;
      irq    <= 1'b0;
    end else begin
      raw_tc <= (raw_tc & ~clr(wr_en && addr == A_RAW_TC, wlo)) | tc_evt;
      raw_e1 <= (raw_e1 & ~clr(wr_en && addr == A_RAW_E1, wlo)) | err1_evt;
      raw_e2 <= (raw_e2 & ~clr(wr_en && addr == A_RAW_E2, wlo)) | err2_evt;
      if (wr_en && addr == A_EN_TC) en_tc <= wlo;
      if (wr_en && addr == A_EN_E1) en_e1 <= wlo;
      if (wr_en && addr == A_EN_E2) en_e2 <= wlo;
      if (wr_en && addr == A_PRIO)  prio  <= wdata;
      irq <= |comb;
    end
  end

  always_comb begin
    case (addr)
      A_COMB:   rdata = DW'(comb);
      A_M_TC:   rdata = DW'(m_tc);
      A_M_E1:   rdata = DW'(m_e1);
      A_M_E2:   rdata = DW'(m_e2);
      A_EN_TC:  rdata = DW'(en_tc);
      A_EN_E1:  rdata = DW'(en_e1);
      A_EN_E2:  rdata = DW'(en_e2);
      A_RAW_TC: rdata = DW'(raw_tc);
      A_RAW_E1: rdata = DW'(raw_e1);
      A_RAW_E2: rdata = DW'(raw_e2);
      A_PRIO:   rdata = prio;
      A_BUSY:   rdata = DW'(busy);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NCH = 16,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tc_evt,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [NCH-1:0] wlo,
  input logic [NCH-1:0] raw_tc,
  input logic [NCH-1:0] raw_e1,
  input logic [NCH-1:0] raw_e2,
  input logic [NCH-1:0] en_tc,
  input logic [NCH-1:0] en_e1,
  input logic [NCH-1:0] en_e2,
  input logic           irq
);
  localparam logic [AW-1:0] C_EN_TC  = AW'(12'h018);
  localparam logic [AW-1:0] C_RAW_TC = AW'(12'h600);

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_evt) |=> ((raw_tc & $past(tc_evt)) == $past(tc_evt))); // R2

  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_tc & ~$past(raw_tc) & ~$past(tc_evt)) == '0)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_RAW_TC) |=> ((raw_tc & $past(wlo) & ~$past(tc_evt)) == '0)); // R3

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == C_EN_TC) |=> $stable(en_tc)); // R5

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|((raw_tc & en_tc) | (raw_e1 & en_e1) | (raw_e2 & en_e2)))); // R8
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .wr_en(wr_en), .addr(addr),
  .wlo(wdata[NCH-1:0]), .raw_tc(raw_tc), .raw_e1(raw_e1), .raw_e2(raw_e2),
  .en_tc(en_tc), .en_e1(en_e1), .en_e2(en_e2), .irq(irq)
);

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
  localparam int NCH = 16, AW = 12, DW = 32;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] tc_evt = '0, err1_evt = '0, err2_evt = '0, busy = '0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dma_irq_agg #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .err1_evt(err1_evt),
    .err2_evt(err2_evt), .busy(busy), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e1, input logic [NCH-1:0] e2);
    @(negedge clk); tc_evt = t; err1_evt = e1; err2_evt = e2;
    @(negedge clk); tc_evt = '0; err1_evt = '0; err2_evt = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 raw tc", 12'h600, 0);
    rd_chk("R1 raw e1", 12'h610, 0);
    rd_chk("R1 raw e2", 12'h618, 0);
    rd_chk("R1 en tc", 12'h018, 0);
    rd_chk("R1 en e1", 12'h020, 0);
    rd_chk("R1 en e2", 12'h024, 0);
    rd_chk("R1 prio", 12'h688, 0);
    chk("R1 irq", DW'(irq), 0);
  endtask

  task automatic t_latch();
    pulse(16'h8001, 16'h0010, 16'h0100);
    repeat (3) @(negedge clk);
    rd_chk("R2 raw tc held", 12'h600, 32'h8001);
    rd_chk("R2 raw e1 held", 12'h610, 32'h0010);
    rd_chk("R2 raw e2 held", 12'h618, 32'h0100);
    rd_chk("R6 masked tc with enable zero", 12'h004, 0);
    chk("R8 irq low while disabled", DW'(irq), 0);
  endtask

  task automatic t_masks();
    wr(12'h018, 32'hFFFF_FFFF);
    rd_chk("R5 en tc upper zero", 12'h018, 32'h0000_FFFF);
    wr(12'h020, 32'h0000_00F0);
    rd_chk("R5 en e1", 12'h020, 32'h0000_00F0);
    rd_chk("R5 en e2 untouched", 12'h024, 0);
    rd_chk("R6 masked tc", 12'h004, 32'h8001);
    rd_chk("R6 masked e1", 12'h00C, 32'h0010);
    rd_chk("R6 masked e2", 12'h010, 0);
    rd_chk("R7 combined", 12'h000, 32'h8011);
    chk("R8 irq high", DW'(irq), 1);
  endtask

  task automatic t_clear();
    wr(12'h600, 32'h0000_0001);
    rd_chk("R3 raw tc partial clear", 12'h600, 32'h8000);
    wr(12'h610, 32'h0000_0010);
    wr(12'h618, 32'h0000_0100);
    rd_chk("R3 raw e1 cleared", 12'h610, 0);
    rd_chk("R3 raw e2 cleared", 12'h618, 0);
    rd_chk("R7 combined after clears", 12'h000, 32'h8000);
    @(negedge clk); wr_en = 1; addr = 12'h600; wdata = 32'h8000;
    @(negedge clk); wr_en = 0; wdata = '0;
    chk("R8 irq still high one cycle", DW'(irq), 1);
    @(negedge clk);
    chk("R8 irq drops", DW'(irq), 0);
    rd_chk("R7 combined zero", 12'h000, 0);
  endtask

  task automatic t_race();
    pulse(16'h0020, 16'h0000, 16'h0000);
    @(negedge clk); tc_evt = 16'h0008; wr_en = 1; addr = 12'h600; wdata = 32'h0028;
    @(negedge clk); tc_evt = '0; wr_en = 0; wdata = '0;
    rd_chk("R4 event beats clear", 12'h600, 32'h0008);
  endtask

  task automatic t_busy();
    @(negedge clk); busy = 16'hA5A5;
    rd_chk("R9 busy word", 12'h690, 32'hA5A5);
    busy = '0;
    rd_chk("R9 busy idle", 12'h690, 0);
  endtask

  task automatic t_prio();
    wr(12'h688, 32'h1234_5678);
    rd_chk("R10 prio readback", 12'h688, 32'h1234_5678);
    wr(12'h688, 32'h0);
    rd_chk("R10 prio equal", 12'h688, 0);
  endtask

  task automatic t_readonly();
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h690, 32'hFFFF_FFFF);
    rd_chk("R11 raw tc unchanged", 12'h600, 32'h0008);
    rd_chk("R11 en tc unchanged", 12'h018, 32'h0000_FFFF);
    rd_chk("R11 en e2 unchanged", 12'h024, 0);
    rd_chk("R11 prio unchanged", 12'h688, 0);
    rd_chk("R11 unmapped read", 12'h100, 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latch();
    t_masks();
    t_clear();
    t_race();
    t_busy();
    t_prio();
    t_readonly();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule